// File: doc/BRIEF.md
# Password-Gated Write Protection Unit

This block sits beside a group of safety-critical control bits and decides when they may be written. Software writes one byte to a key register. The upper five bits of that byte form a key and the lower two bits carry a scheme mode. A byte carrying the unlock key opens a short write window. A byte carrying the lock key shuts the window at once. If nothing shuts the window, it closes by itself after a fixed number of clock cycles. A third key is the only way to change the scheme mode.

The block drives a write-allow output, and the registers that hold the protected bits use it as their write enable. When the scheme mode is 00 the guard is switched off and writes are always allowed. The key register reads back the current mode and the protection status. The key field always reads back as zero.

Top module: `wrlock_guard`

## Requirements
- R1: After reset the key register reads 0x07 (mode 11, status 1, key field 0), `lock_o` is 1 and `wr_allow_o` is 0.
- R2: The mode field is bits [1:0]. Mode 00 disables the guard: `lock_o` is 0 and `wr_allow_o` is 1 regardless of the window. Any nonzero mode enables the guard.
- R3: With the guard enabled, writing key 10011 in bits [7:3] (byte 0x98) opens the window. `lock_o` goes to 0 in the cycle after the write.
- R4: Writing key 10101 (byte 0xA8) closes an open window. `lock_o` is 1 in the cycle after the write.
- R5: An open window that is not closed stays open for exactly WINDOW_CYCLES cycles after the write cycle (32 by default), and then closes by itself.
- R6: Writing the unlock key while the window is open restarts the full WINDOW_CYCLES count.
- R7: Writing key 11000 (bytes 0xC0 to 0xC3) loads the mode from bits [1:0] of the same byte and shuts any open window.
- R8: A write whose key is none of the three keys changes neither the mode nor the window.
- R9: Bit 2 of the read value is the protection status and equals `lock_o`. Bits [7:3] read as 0.
- R10: When the mode is 00, the unlock key is ignored. No window is pending when the guard is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also paces the window count |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_we | input | 1 | Write strobe for the key register |
| key_wdata | input | 8 | Write byte: key in [7:3], mode in [1:0] |
| key_rdata | output | 8 | Read value: 0 in [7:3], status in [2], mode in [1:0] |
| lock_o | output | 1 | 1 while protected bits may not be written |
| wr_allow_o | output | 1 | Write enable for the protected bits |

## Verification
The assertions assume that `key_we` and `key_wdata` are defined and stable around each rising edge. They also assume that a write strobe lasts exactly one clock, so that each write is a single event and a countdown step is never confused with a reload. The bench meets this by driving every input on the falling edge and dropping the strobe after one cycle. It samples on falling edges as well, so each window length is counted in whole cycles from the write edge.

// File: rtl/wlg_pkg.sv
package wlg_pkg;
   typedef enum logic [1:0] {
      KEY_NONE  = 2'd0,
      KEY_OPEN  = 2'd1,
      KEY_CLOSE = 2'd2,
      KEY_MODE  = 2'd3
   } key_e;

   localparam int NUM_KEYS = 3;
endpackage

// File: rtl/wlg_key_decode.sv
module wlg_key_decode #(
   parameter int                PASS_W    = 5,
   parameter logic [PASS_W-1:0] OPEN_KEY  = 5'b10011,
   parameter logic [PASS_W-1:0] CLOSE_KEY = 5'b10101,
   parameter logic [PASS_W-1:0] MODE_KEY  = 5'b11000
) (
   input  logic              we,
   input  logic [PASS_W-1:0] pass,
   output wlg_pkg::key_e     key
);
   import wlg_pkg::*;

   localparam logic [PASS_W-1:0] KEY_TAB [NUM_KEYS] = '{OPEN_KEY, CLOSE_KEY, MODE_KEY};

   logic [NUM_KEYS-1:0] hit;

   for (genvar i = 0; i < NUM_KEYS; i++) begin : g_cmp
      assign hit[i] = we && (pass == KEY_TAB[i]);
   end

   if ((OPEN_KEY == CLOSE_KEY) || (OPEN_KEY == MODE_KEY) || (CLOSE_KEY == MODE_KEY)) begin : g_bad_keys
      $error("wlg_key_decode: keys must be distinct");
   end

   always_comb begin
      unique case (hit)
         3'b001:  key = KEY_OPEN;
         3'b010:  key = KEY_CLOSE;
         3'b100:  key = KEY_MODE;
         default: key = KEY_NONE;
      endcase
   end
endmodule

// File: rtl/wlg_mode_reg.sv
module wlg_mode_reg #(
   parameter int                MODE_W     = 2,
   parameter logic [MODE_W-1:0] MODE_RESET = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [MODE_W-1:0] load_val,
   output logic [MODE_W-1:0] mode,
   output logic              enabled
);
   if (MODE_W < 1) begin : g_bad_w
      $error("wlg_mode_reg: MODE_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mode <= MODE_RESET;
      else if (load) mode <= load_val;
   end

   assign enabled = |mode;

   // R8: mode moves only on its own key
   assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(mode));
   // R7: mode takes the written low bits
   assert_mode_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (mode == $past(load_val)));
endmodule

// File: rtl/wlg_window_timer.sv
module wlg_window_timer #(
   parameter int WINDOW_CYCLES = 32,
   localparam int CNT_W = $clog2(WINDOW_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic disarm,
   output logic open
);
   localparam logic [CNT_W-1:0] RELOAD = CNT_W'(WINDOW_CYCLES);

   if (WINDOW_CYCLES < 1) begin : g_bad_win
      $error("wlg_window_timer: WINDOW_CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (disarm)     cnt <= '0;
      else if (arm)        cnt <= RELOAD;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign open = (cnt != '0);

   // R3/R6: an accepted unlock loads the full window
   assert_window_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (arm && !disarm) |=> (cnt == RELOAD));
   // R4: lock empties the window
   assert_window_shut_R4: assert property (@(posedge clk) disable iff (!rst_n)
      disarm |=> !open);
   // R5: an idle window counts down by one per cycle
   assert_window_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (open && !arm && !disarm) |=> (cnt == $past(cnt) - 1'b1));
   // R8: a closed window with no request stays closed
   assert_window_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!open && !arm) |=> !open);
endmodule

// File: rtl/wrlock_guard.sv
module wrlock_guard #(
   parameter int WINDOW_CYCLES = 32,
   parameter int DATA_W        = 8,
   parameter int PASS_W        = 5,
   parameter int MODE_W        = 2,
   parameter logic [PASS_W-1:0] OPEN_KEY  = 5'b10011,
   parameter logic [PASS_W-1:0] CLOSE_KEY = 5'b10101,
   parameter logic [PASS_W-1:0] MODE_KEY  = 5'b11000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_we,
   input  logic [DATA_W-1:0] key_wdata,
   output logic [DATA_W-1:0] key_rdata,
   output logic              lock_o,
   output logic              wr_allow_o
);
   import wlg_pkg::*;

   localparam int STAT_BIT = MODE_W;
   localparam int PASS_LSB = MODE_W + 1;

   if (PASS_LSB + PASS_W != DATA_W) begin : g_bad_layout
      $error("wrlock_guard: PASS_W + MODE_W + 1 must equal DATA_W");
   end

   key_e              key;
   logic [MODE_W-1:0] mode;
   logic              enabled;
   logic              win_open;

   wlg_key_decode #(
      .PASS_W(PASS_W), .OPEN_KEY(OPEN_KEY), .CLOSE_KEY(CLOSE_KEY), .MODE_KEY(MODE_KEY)
   ) u_dec (
      .we   (key_we),
      .pass (key_wdata[DATA_W-1:PASS_LSB]),
      .key  (key)
   );

   wlg_mode_reg #(.MODE_W(MODE_W), .MODE_RESET('1)) u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (key == KEY_MODE),
      .load_val (key_wdata[MODE_W-1:0]),
      .mode     (mode),
      .enabled  (enabled)
   );

   wlg_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    ((key == KEY_OPEN) && enabled),
      .disarm ((key == KEY_CLOSE) || (key == KEY_MODE)),
      .open   (win_open)
   );

   assign lock_o     = enabled && !win_open;
   assign wr_allow_o = !lock_o;
   assign key_rdata  = {{PASS_W{1'b0}}, lock_o, mode};

   // R2: a disabled guard never locks
   assert_disabled_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == '0) |-> (wr_allow_o && !lock_o));
   // R4: a lock write leaves the guard locked or disabled next cycle
   assert_close_locks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (key_we && key_wdata[DATA_W-1:PASS_LSB] == CLOSE_KEY) |=> (lock_o || mode == '0));
endmodule

// File: tb/sim_wrlock_guard.sv
`timescale 1ns/1ps
module sim_wrlock_guard;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       key_we = 1'b0;
   logic [7:0] key_wdata = 8'h00;
   logic [7:0] key_rdata;
   logic       lock_o, wr_allow_o;

   int n_chk = 0;
   int n_bad = 0;

   localparam logic [7:0] B_OPEN  = 8'h98;
   localparam logic [7:0] B_CLOSE = 8'hA8;
   localparam logic [7:0] B_MODE  = 8'hC0;

   always #5 clk = ~clk;

   wrlock_guard u0 (
      .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_wdata(key_wdata),
      .key_rdata(key_rdata), .lock_o(lock_o), .wr_allow_o(wr_allow_o)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic expect_state(input string req, input logic lk, input logic [1:0] md);
      check(req, key_rdata, {5'b0, lk, md});
      check(req, {7'b0, lock_o}, {7'b0, lk});
      check(req, {7'b0, wr_allow_o}, {7'b0, !lk});
   endtask

   task automatic wr(input logic [7:0] b);
      @(negedge clk); key_we = 1'b1; key_wdata = b;
      @(negedge clk); key_we = 1'b0; key_wdata = 8'h00;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset;
      expect_state("R1", 1'b1, 2'b11);
   endtask

   task automatic t_open_close;
      wr(B_OPEN);
      expect_state("R3", 1'b0, 2'b11);
      check("R9", key_rdata & 8'hF8, 8'h00);
      idle(5);
      wr(B_CLOSE);
      expect_state("R4", 1'b1, 2'b11);
   endtask

   task automatic t_timeout;
      wr(B_OPEN);
      idle(31);
      expect_state("R5 last open cycle", 1'b0, 2'b11);
      idle(1);
      expect_state("R5 auto close", 1'b1, 2'b11);
   endtask

   task automatic t_restart;
      wr(B_OPEN);
      idle(20);
      wr(B_OPEN);
      idle(31);
      expect_state("R6 still open", 1'b0, 2'b11);
      idle(1);
      expect_state("R6 closed", 1'b1, 2'b11);
   endtask

   task automatic t_ignored;
      wr(8'h03 ^ 8'h01);
      expect_state("R8 plain write", 1'b1, 2'b11);
      wr({5'b10011, 3'b000} ^ 8'h40);
      expect_state("R8 bad key", 1'b1, 2'b11);
      wr(B_OPEN);
      wr(8'hF8);
      expect_state("R8 bad key keeps window", 1'b0, 2'b11);
      wr(B_CLOSE);
   endtask

   task automatic t_mode;
      wr(B_MODE | 8'h01);
      expect_state("R7 mode 01", 1'b1, 2'b01);
      wr(B_OPEN);
      wr(B_MODE | 8'h02);
      expect_state("R7 mode write shuts window", 1'b1, 2'b10);
      wr(B_MODE);
      expect_state("R2 disabled", 1'b0, 2'b00);
      wr(B_CLOSE);
      expect_state("R2 close while disabled", 1'b0, 2'b00);
      wr(B_OPEN);
      wr(B_MODE | 8'h03);
      expect_state("R10 open ignored when disabled", 1'b1, 2'b11);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_open_close();
      t_timeout();
      t_restart();
      t_ignored();
      t_mode();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #200000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule